// File: doc/BRIEF.md
# DRAM Refresh Request Scheduler

This block decides when a DRAM controller has to refresh. Every row has to be refreshed once within each retention window (typically 64 ms), so the block counts clock cycles and earns refresh credits. Each credit is a refresh that is owed. The block asks the command sequencer for a refresh for as long as any credit is outstanding. Each grant pays back one credit and moves a next-row pointer forward.

Two policies are available:
- **Spread policy:** earns one credit per row period. For example, 8192 rows in 64 ms gives one credit every 7.8 µs, which is 780 cycles at 100 MHz.
- **Burst policy:** earns a full window's worth of credits (one per row) in a single step at the end of each window, so the sequencer can refresh all rows back to back.

The policy input is sampled only at a window boundary.

A refresh that the sequencer postpones is not lost. It stays in the debt count. If that count passes a set limit, a sticky error flag is raised. The row pointer is only useful when the controller supplies the row address. When the DRAM counts rows internally, a build option ties the row output to zero.

Top module: `refresh_sched`

## Requirements
- R1: After reset the request, debt count, row output and error flag are all zero, and the policy is spread (policy input 0 = spread, 1 = burst).
- R2: In the spread policy one credit is earned every TICK_CYCLES clock cycles. The first credit appears on the TICK_CYCLES-th rising edge after reset is released.
- R3: The request stays high, and the debt does not fall, until a grant is seen while the request is high. Each such grant lowers the debt by exactly one.
- R4: Each accepted grant advances the row output by one, wrapping from ROWS-1 to 0. With EXT_ROW_ADDR = 0 the row output stays 0.
- R5: The debt output counts credits earned minus grants accepted. The request is high exactly when the debt is nonzero.
- R6: A grant while the request is low has no effect: the row output and debt keep their values.
- R7: The error flag goes high on the edge at which the debt first exceeds DEBT_LIMIT, and stays high until reset.
- R8: In the burst policy no credit is earned inside a window. ROWS credits are added on the last tick of each window, where a window is ROWS row periods.
- R9: The policy input takes effect only at a window end. The window that is ending earns its credits under the old policy.
- R10: When a credit and an accepted grant fall on the same edge, the debt changes by their net amount.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_burst_i | input | 1 | Requested policy: 0 spread, 1 burst (applied at the next window end) |
| ref_gnt_i | input | 1 | Grant from the command sequencer; counts only while the request is high |
| ref_req_o | output | 1 | Refresh request; high while debt is nonzero |
| ref_row_o | output | ROW_W | Row to refresh next (external-address builds) |
| debt_o | output | DEBT_W | Refreshes owed but not yet granted |
| debt_err_o | output | 1 | Sticky flag: debt went above DEBT_LIMIT |

## Verification
The hardest case to reach is a policy change that lands in the middle of a window. The ending window must still pay out under the old policy, and the next window must follow the new one. The bench raises the burst input right after reset and checks that spread credits still arrive through the whole first window. It then releases the input partway through a burst window and checks that the following window end still delivers a full batch of ROWS credits. Overflow of the debt is reached by holding off grants for more ticks than the limit allows, and then draining the debt to show that the error flag stays set.

// File: rtl/refresh_sched_pkg.sv
package refresh_sched_pkg;

   typedef enum logic {
      REF_SPREAD = 1'b0,
      REF_BURST  = 1'b1
   } ref_mode_e;

   function automatic int unsigned width_of(input int unsigned count);
      return (count < 2) ? 1 : $clog2(count);
   endfunction

endpackage

// File: rtl/refresh_tick_gen.sv
module refresh_tick_gen #(
   parameter int unsigned TICK_CYCLES = 780,
   parameter int unsigned ROWS        = 8192
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o,
   output logic win_end_o
);
   import refresh_sched_pkg::*;

   localparam int unsigned TW = width_of(TICK_CYCLES);
   localparam int unsigned WW = width_of(ROWS);
   localparam logic [TW-1:0] TICK_LAST = TW'(TICK_CYCLES - 1);
   localparam logic [WW-1:0] ROW_LAST  = WW'(ROWS - 1);

   logic [TW-1:0] cyc_q;
   logic [WW-1:0] slot_q;

   assign tick_o    = (cyc_q == TICK_LAST);
   assign win_end_o = tick_o && (slot_q == ROW_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc_q  <= '0;
         slot_q <= '0;
      end else if (tick_o) begin
         cyc_q  <= '0;
         slot_q <= (slot_q == ROW_LAST) ? '0 : slot_q + 1'b1;
      end else begin
         cyc_q  <= cyc_q + 1'b1;
      end
   end

endmodule

// File: rtl/refresh_debt_ctr.sv
module refresh_debt_ctr #(
   parameter int unsigned ROWS       = 8192,
   parameter int unsigned DEBT_LIMIT = 8192,
   parameter int unsigned DEBT_W     = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              win_end_i,
   input  logic              burst_i,
   input  logic              take_i,
   output logic [DEBT_W-1:0] debt_o,
   output logic              err_o
);
   localparam logic [DEBT_W:0] DEBT_MAX  = {1'b0, {DEBT_W{1'b1}}};
   localparam logic [DEBT_W:0] LIMIT_EXT = (DEBT_W + 1)'(DEBT_LIMIT);
   localparam logic [DEBT_W:0] BATCH     = (DEBT_W + 1)'(ROWS);

   logic [DEBT_W-1:0] debt_q;
   logic              err_q;
   logic [DEBT_W:0]   earn;
   logic [DEBT_W:0]   sum;
   logic [DEBT_W:0]   next;

   always_comb begin
      if (burst_i) earn = win_end_i ? BATCH : '0;
      else         earn = tick_i ? (DEBT_W + 1)'(1) : '0;
      sum  = {1'b0, debt_q} + earn - {{DEBT_W{1'b0}}, take_i};
      next = (sum > DEBT_MAX) ? DEBT_MAX : sum;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         debt_q <= '0;
         err_q  <= 1'b0;
      end else begin
         debt_q <= next[DEBT_W-1:0];
         err_q  <= err_q | (next > LIMIT_EXT);
      end
   end

   assign debt_o = debt_q;
   assign err_o  = err_q;

endmodule

// File: rtl/refresh_row_ctr.sv
module refresh_row_ctr #(
   parameter int unsigned ROWS         = 8192,
   parameter bit          EXT_ROW_ADDR = 1'b1,
   parameter int unsigned ROW_W        = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take_i,
   output logic [ROW_W-1:0] row_o
);
   localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

   generate
      if (EXT_ROW_ADDR) begin : g_ext
         logic [ROW_W-1:0] row_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      row_q <= '0;
            else if (take_i) row_q <= (row_q == ROW_LAST) ? '0 : row_q + 1'b1;
         end
         assign row_o = row_q;
      end else begin : g_int
         assign row_o = '0;
      end
   endgenerate

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
   import refresh_sched_pkg::*;
#(
   parameter int unsigned TICK_CYCLES  = 780,
   parameter int unsigned ROWS         = 8192,
   parameter int unsigned DEBT_LIMIT   = 8192,
   parameter bit          EXT_ROW_ADDR = 1'b1,
   localparam int unsigned ROW_W       = width_of(ROWS),
   localparam int unsigned DEBT_W      = width_of(DEBT_LIMIT + ROWS + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_burst_i,
   input  logic              ref_gnt_i,
   output logic              ref_req_o,
   output logic [ROW_W-1:0]  ref_row_o,
   output logic [DEBT_W-1:0] debt_o,
   output logic              debt_err_o
);

   generate
      if (TICK_CYCLES < 2) begin : g_bad_tick
         $error("refresh_sched: TICK_CYCLES must be at least 2");
      end
      if (ROWS < 2) begin : g_bad_rows
         $error("refresh_sched: ROWS must be at least 2");
      end
      if (DEBT_LIMIT < ROWS) begin : g_bad_limit
         $error("refresh_sched: DEBT_LIMIT must cover one burst of ROWS");
      end
   endgenerate

   logic      tick;
   logic      win_end;
   logic      take;
   ref_mode_e mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mode_q <= REF_SPREAD;
      else if (win_end) mode_q <= mode_burst_i ? REF_BURST : REF_SPREAD;
   end

   assign ref_req_o = (debt_o != '0);
   assign take      = ref_req_o && ref_gnt_i;

   refresh_tick_gen #(
      .TICK_CYCLES (TICK_CYCLES),
      .ROWS        (ROWS)
   ) u_tick (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_o    (tick),
      .win_end_o (win_end)
   );

   refresh_debt_ctr #(
      .ROWS       (ROWS),
      .DEBT_LIMIT (DEBT_LIMIT),
      .DEBT_W     (DEBT_W)
   ) u_debt (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick),
      .win_end_i (win_end),
      .burst_i   (mode_q == REF_BURST),
      .take_i    (take),
      .debt_o    (debt_o),
      .err_o     (debt_err_o)
   );

   refresh_row_ctr #(
      .ROWS         (ROWS),
      .EXT_ROW_ADDR (EXT_ROW_ADDR),
      .ROW_W        (ROW_W)
   ) u_row (
      .clk    (clk),
      .rst_n  (rst_n),
      .take_i (take),
      .row_o  (ref_row_o)
   );

endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
   parameter int unsigned ROWS       = 8,
   parameter int unsigned DEBT_LIMIT = 8,
   parameter bit          EXT_ROW    = 1'b1,
   parameter int unsigned ROW_W      = 3,
   parameter int unsigned DEBT_W     = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ref_gnt_i,
   input logic              ref_req_o,
   input logic [ROW_W-1:0]  ref_row_o,
   input logic [DEBT_W-1:0] debt_o,
   input logic              debt_err_o
);
   localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

   assert_req_tracks_debt_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ref_req_o == (debt_o != '0));

   assert_row_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (EXT_ROW && ref_req_o && ref_gnt_i) |=>
         ref_row_o == (($past(ref_row_o) == ROW_LAST) ? '0 : $past(ref_row_o) + 1'b1));

   assert_idle_grant_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !ref_req_o |=> $stable(ref_row_o));

   assert_hold_without_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_req_o && !ref_gnt_i) |=> (ref_req_o && debt_o >= $past(debt_o)));

   assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      debt_err_o |=> debt_err_o);

   assert_err_on_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (debt_o > DEBT_W'(DEBT_LIMIT)) |-> debt_err_o);

endmodule

bind refresh_sched refresh_sched_chk #(
   .ROWS       (ROWS),
   .DEBT_LIMIT (DEBT_LIMIT),
   .EXT_ROW    (EXT_ROW_ADDR),
   .ROW_W      (ROW_W),
   .DEBT_W     (DEBT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ref_gnt_i  (ref_gnt_i),
   .ref_req_o  (ref_req_o),
   .ref_row_o  (ref_row_o),
   .debt_o     (debt_o),
   .debt_err_o (debt_err_o)
);

// File: tb/refresh_sched_tb.sv
`timescale 1ns/1ps
module refresh_sched_tb;

   localparam int unsigned TICK  = 10;
   localparam int unsigned ROWS  = 8;
   localparam int unsigned LIMIT = 12;
   localparam int unsigned ROW_W = 3;
   localparam int unsigned DW    = $clog2(LIMIT + ROWS + 2);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mode_burst = 1'b0;
   logic          gnt = 1'b0;
   logic          req;
   logic [ROW_W-1:0] row;
   logic [DW-1:0] debt;
   logic          err;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 0;

   always #4 clk = ~clk;

   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   refresh_sched #(
      .TICK_CYCLES  (TICK),
      .ROWS         (ROWS),
      .DEBT_LIMIT   (LIMIT),
      .EXT_ROW_ADDR (1'b1)
   ) u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .mode_burst_i (mode_burst),
      .ref_gnt_i    (gnt),
      .ref_req_o    (req),
      .ref_row_o    (row),
      .debt_o       (debt),
      .debt_err_o   (err)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   task automatic go(input int n);
      while (cyc < n) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      gnt = 1'b0;
      mode_burst = 1'b0;
      @(posedge clk);
      @(posedge clk);
      #1 rst_n = 1'b1;
   endtask

   task automatic t_reset();
      do_reset();
      check("R1 req", req, 0);
      check("R1 debt", debt, 0);
      check("R1 row", row, 0);
      check("R1 err", err, 0);
   endtask

   task automatic t_spread();
      do_reset();
      go(9);  check("R2 no credit before period", req, 0);
      go(10); check("R2 first credit", debt, 1);
      gnt = 1'b1;
      go(11); check("R3 grant clears", debt, 0);
              check("R4 row advance", row, 1);
      go(12); check("R6 idle grant row", row, 1);
              check("R6 idle grant debt", debt, 0);
      gnt = 1'b0;
      go(29); check("R3 request held", req, 1);
              check("R3 row held", row, 1);
      go(40); check("R5 debt accumulates", debt, 3);
      gnt = 1'b1;
      go(41); check("R5 drain", debt, 2);
      go(43); check("R5 drained", debt, 0);
              check("R4 row after drain", row, 4);
      go(81); check("R4 row wrap", row, 0);
              check("R5 req low", req, 0);
      gnt = 1'b0;
   endtask

   task automatic t_overflow();
      do_reset();
      go(120); check("R7 at limit debt", debt, 12);
               check("R7 at limit err", err, 0);
      go(130); check("R7 over limit err", err, 1);
               check("R7 over limit debt", debt, 13);
      gnt = 1'b1;
      go(140); check("R10 net on credit+grant", debt, 4);
      go(145); check("R7 drained debt", debt, 0);
               check("R7 err sticky", err, 1);
               check("R4 row after 14 grants", row, 6);
      gnt = 1'b0;
   endtask

   task automatic t_burst();
      do_reset();
      mode_burst = 1'b1;
      gnt = 1'b1;
      go(10); check("R9 old policy still spread", debt, 1);
      go(80); check("R9 window end spread credit", debt, 1);
      go(85); check("R8 drained", debt, 0);
      gnt = 1'b0;
      go(155); check("R8 no credit inside burst window", req, 0);
      go(160); check("R8 batch at window end", debt, 8);
      gnt = 1'b1;
      go(164); check("R8 burst drain row", row, 4);
      go(168); check("R8 burst drained", debt, 0);
      mode_burst = 1'b0;
      go(235); check("R9 change waits for window end", debt, 0);
      gnt = 1'b0;
      go(240); check("R9 ending window stays burst", debt, 8);
      go(250); check("R9 spread after boundary", debt, 9);
      check("R8 no overflow", err, 0);
   endtask

   initial begin
      t_reset();
      t_spread();
      t_overflow();
      t_burst();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #200000;
      if (!done) begin
         done = 1;
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule